// File: doc/BRIEF.md
# Flash Command Interface Controller

This block is the command decoder and operation sequencer for a 16-bit NOR-style flash. The host issues synchronous bus writes whose low data byte carries a command code; the block turns them into a read mode (array, identifier or status), arms and launches word programs and block erases, and lets a running operation be suspended and resumed. An 8-bit status register reports readiness, suspension and error flags.

The storage cells sit outside the block behind a simple synchronous port: the block drives the address, reads back the current word one clock later, and at the end of a program issues a one-cycle write of the merged word. At the end of an erase it issues a one-cycle erase request carrying the first and last word address of the decoded block. Program and erase durations are parameter-set cycle counts. Supply health is reduced to one `vpp_ok` input that is sampled when an operation is launched.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: After reset the block is in array-read mode, a status read returns 0080h, and command FFh returns it to array-read mode from any idle mode.
- R2: After command 90h a read of address 0 returns 002Ch, a read of address 1 returns 4492h when `TOP_BOOT` is 1 and 4493h when it is 0, and any other address returns 0000h.
- R3: After command 70h reads return {8'h00, status}, with bit 7 ready, bit 6 erase suspended, bit 5 erase error, bit 4 program error, bit 3 supply abort, bit 2 program suspended, bits 1 and 0 zero; the value is captured on each `bus_re` strobe and held until the next strobe.
- R4: Command 10h or 40h arms a program; the next write supplies address and data, and on completion the stored word becomes old AND new, so 1 bits leave cells unchanged. The block then shows status.
- R5: Command 20h followed by D0h at any address of a block sets every word of that block to FFFFh; the address space holds eight 4K-word parameter blocks at the top (`TOP_BOOT`=1) or bottom and thirty-one 32K-word main blocks.
- R6: If the write after 20h does not carry D0h, bits 5 and 4 of status are set and nothing is erased.
- R7: While a program or erase runs, every command other than B0h is ignored.
- R8: B0h during a running program or erase stops it with ready=1 and bit 2 or bit 6 set; the remaining count is kept, and D0h resumes it and clears the suspend bit.
- R9: In erase suspend only FFh, 70h, D0h and 10h/40h are honoured; a program launched there runs to completion ignoring all commands and returns to erase suspend with bit 6 still set.
- R10: Command 50h clears bits 5, 4 and 3 and selects array-read mode; these error bits stay set until it arrives.
- R11: If `vpp_ok` is low when a program data write or erase confirm arrives, nothing starts, bit 3 is set and the cells are unchanged.
- R12: In program suspend only FFh, 70h and D0h are honoured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vpp_ok | input | 1 | Programming supply within range |
| bus_we | input | 1 | Host write strobe (command or data) |
| bus_re | input | 1 | Host read strobe |
| bus_addr | input | AW | Host word address |
| bus_wdata | input | 16 | Host write data, command on bits 7:0 |
| bus_rdata | output | 16 | Read data, valid the cycle after `bus_re` |
| mem_addr | output | AW | Cell array read/write address |
| mem_rdata | input | 16 | Cell array word, registered from `mem_addr` |
| mem_we | output | 1 | One-cycle word write at `mem_addr` |
| mem_wdata | output | 16 | Merged word to write |
| mem_ers | output | 1 | One-cycle block erase request |
| mem_ers_first | output | AW | First word of the block to erase |
| mem_ers_last | output | AW | Last word of the block to erase |

## Verification
The bench aims at the mode-dependent acceptance rules: commands issued mid-program, identify and program-setup codes issued during a suspend, and a program nested inside an erase suspend; a decoder that honoured them would change the read mode or corrupt words that the bench later reads back. It checks that a status value polled while busy stays frozen until the next strobe, which a free-running status path would break, and that writing 1s over a programmed word keeps its 0s. A second instance with the bottom placement exposes both the identifier and the erase ranges, so a swapped block decode shows as a wrong first or last address, and a bad confirm or low supply that still erased would show up as lost data.

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl #(
  parameter int AW         = 20,
  parameter int PGM_CYCLES = 8,
  parameter int ERS_CYCLES = 40,
  parameter int PAR_BITS   = 12,
  parameter int MAIN_BITS  = 15,
  parameter bit TOP_BOOT   = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          vpp_ok,
  input  logic          bus_we,
  input  logic          bus_re,
  input  logic [AW-1:0] bus_addr,
  input  logic [15:0]   bus_wdata,
  output logic [15:0]   bus_rdata,
  output logic [AW-1:0] mem_addr,
  input  logic [15:0]   mem_rdata,
  output logic          mem_we,
  output logic [15:0]   mem_wdata,
  output logic          mem_ers,
  output logic [AW-1:0] mem_ers_first,
  output logic [AW-1:0] mem_ers_last
);

  localparam int MAXC = (PGM_CYCLES > ERS_CYCLES) ? PGM_CYCLES : ERS_CYCLES;
  localparam int CW   = $clog2(MAXC + 1);
  localparam logic [AW-1:0] PMASK = {{(AW-PAR_BITS){1'b0}}, {PAR_BITS{1'b1}}};
  localparam logic [AW-1:0] MMASK = {{(AW-MAIN_BITS){1'b0}}, {MAIN_BITS{1'b1}}};
  localparam logic [15:0] ID_MFR = 16'h002C;
  localparam logic [15:0] ID_DEV = TOP_BOOT ? 16'h4492 : 16'h4493;

  typedef enum logic [2:0] {OP_IDLE, OP_PGM, OP_PGM_SUSP, OP_ERS, OP_ERS_SUSP, OP_PGM_IN_ERS} op_t;
  typedef enum logic [1:0] {RM_ARRAY, RM_ID, RM_STATUS} rmode_t;
  typedef enum logic [1:0] {PH_NONE, PH_PGM, PH_ERS} phase_t;

  op_t           op_q;
  rmode_t        mode_q;
  phase_t        ph_q;
  logic [CW-1:0] pgm_cnt, ers_cnt;
  logic [AW-1:0] pgm_addr, ers_addr;
  logic [15:0]   pgm_data, rd_q;
  logic          e5, e4, e3, pgm_run_q;

  wire [7:0] cmd      = bus_wdata[7:0];
  wire       pgm_run  = (op_q == OP_PGM) || (op_q == OP_PGM_IN_ERS);
  wire       ers_run  = (op_q == OP_ERS);
  wire       busy     = pgm_run || ers_run;
  wire       sus_hit  = bus_we && ph_q == PH_NONE && (op_q == OP_PGM || op_q == OP_ERS) && cmd == 8'hB0;
  wire       pgm_done = pgm_run && pgm_cnt == CW'(1) && pgm_run_q && !sus_hit;
  wire       ers_done = ers_run && ers_cnt == CW'(1) && !sus_hit;
  wire [7:0] sr       = {~busy, (op_q == OP_ERS_SUSP) || (op_q == OP_PGM_IN_ERS), e5, e4, e3,
                         op_q == OP_PGM_SUSP, 2'b00};

  wire is_par = TOP_BOOT ? (&ers_addr[AW-1:MAIN_BITS]) : ~(|ers_addr[AW-1:MAIN_BITS]);
  wire [AW-1:0] ers_mask = is_par ? PMASK : MMASK;

  assign mem_addr      = pgm_run ? pgm_addr : bus_addr;
  assign mem_we        = pgm_done;
  assign mem_wdata     = mem_rdata & pgm_data;
  assign mem_ers       = ers_done;
  assign mem_ers_first = ers_addr & ~ers_mask;
  assign mem_ers_last  = ers_addr | ers_mask;
  assign bus_rdata     = (mode_q == RM_ARRAY) ? mem_rdata : rd_q;

  wire [15:0] id_val = (bus_addr == '0) ? ID_MFR :
                       (bus_addr == AW'(1)) ? ID_DEV : 16'h0000;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_q <= '0;
    else if (bus_re) rd_q <= (mode_q == RM_STATUS) ? {8'h00, sr} : id_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q <= OP_IDLE;  mode_q <= RM_ARRAY;  ph_q <= PH_NONE;
      pgm_cnt <= '0;  ers_cnt <= '0;  pgm_addr <= '0;  ers_addr <= '0;
      pgm_data <= '0;  e5 <= 1'b0;  e4 <= 1'b0;  e3 <= 1'b0;  pgm_run_q <= 1'b0;
    end else begin
      pgm_run_q <= pgm_run;
      if (pgm_run && pgm_cnt > CW'(1)) pgm_cnt <= pgm_cnt - CW'(1);
      if (ers_run && ers_cnt > CW'(1)) ers_cnt <= ers_cnt - CW'(1);
      if (pgm_done) op_q <= (op_q == OP_PGM_IN_ERS) ? OP_ERS_SUSP : OP_IDLE;
      if (ers_done) op_q <= OP_IDLE;
      if (bus_we) begin
        unique case (ph_q)
          PH_PGM: begin
            ph_q   <= PH_NONE;
            mode_q <= RM_STATUS;
            if (vpp_ok) begin
              pgm_addr <= bus_addr;
              pgm_data <= bus_wdata;
              pgm_cnt  <= CW'(PGM_CYCLES);
              op_q     <= (op_q == OP_ERS_SUSP) ? OP_PGM_IN_ERS : OP_PGM;
            end else e3 <= 1'b1;
          end
          PH_ERS: begin
            ph_q   <= PH_NONE;
            mode_q <= RM_STATUS;
            if (cmd != 8'hD0) begin
              e5 <= 1'b1;
              e4 <= 1'b1;
            end else if (vpp_ok) begin
              ers_addr <= bus_addr;
              ers_cnt  <= CW'(ERS_CYCLES);
              op_q     <= OP_ERS;
            end else e3 <= 1'b1;
          end
          default: begin
            case (op_q)
              OP_IDLE: begin
                case (cmd)
                  8'hFF: mode_q <= RM_ARRAY;
                  8'h90: mode_q <= RM_ID;
                  8'h70: mode_q <= RM_STATUS;
                  8'h50: begin
                    e5 <= 1'b0;  e4 <= 1'b0;  e3 <= 1'b0;
                    mode_q <= RM_ARRAY;
                  end
                  8'h10, 8'h40: begin ph_q <= PH_PGM; mode_q <= RM_STATUS; end
                  8'h20: begin ph_q <= PH_ERS; mode_q <= RM_STATUS; end
                  default: ;
                endcase
              end
              OP_PGM: if (cmd == 8'hB0) begin op_q <= OP_PGM_SUSP; mode_q <= RM_STATUS; end
              OP_ERS: if (cmd == 8'hB0) begin op_q <= OP_ERS_SUSP; mode_q <= RM_STATUS; end
              OP_PGM_SUSP: begin
                case (cmd)
                  8'hFF: mode_q <= RM_ARRAY;
                  8'h70: mode_q <= RM_STATUS;
                  8'hD0: begin op_q <= OP_PGM; mode_q <= RM_STATUS; end
                  default: ;
                endcase
              end
              OP_ERS_SUSP: begin
                case (cmd)
                  8'hFF: mode_q <= RM_ARRAY;
                  8'h70: mode_q <= RM_STATUS;
                  8'hD0: begin op_q <= OP_ERS; mode_q <= RM_STATUS; end
                  8'h10, 8'h40: begin ph_q <= PH_PGM; mode_q <= RM_STATUS; end
                  default: ;
                endcase
              end
              default: ;
            endcase
          end
        endcase
      end
    end
  end

  a_r8_suspend_ready: assert property (@(posedge clk) disable iff (!rst_n)
    sus_hit |=> (sr[7] && (sr[6] || sr[2])));

  a_r7_busy_ignores: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && bus_we && ph_q == PH_NONE && !sus_hit) |=> ($stable(mode_q) && $stable({e5, e4, e3})));

  a_r10_clear_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && ph_q == PH_NONE && op_q == OP_IDLE && cmd == 8'h50) |=> (!e5 && !e4 && !e3 && mode_q == RM_ARRAY));

  a_r6_error_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (e5 && !(bus_we && ph_q == PH_NONE && op_q == OP_IDLE && cmd == 8'h50)) |=> e5);

  a_r5_block_span: assert property (@(posedge clk) disable iff (!rst_n)
    mem_ers |-> ((mem_ers_last - mem_ers_first) == PMASK || (mem_ers_last - mem_ers_first) == MMASK));

  a_r9_single_commit: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_we && mem_ers));

  a_r4_commit_after_run: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> !sr[2] && $past(pgm_run_q));

endmodule

// File: tb/flash_cmd_ctrl_tb_top.sv
`timescale 1ns/1ps
module flash_cmd_ctrl_tb_top;
  localparam int AW = 20;
  localparam int PGM_CYCLES = 8;

  logic clk = 1'b0, rst_n = 1'b0, vpp_ok = 1'b1;
  logic bus_we = 1'b0, bus_re = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  always #4 clk = ~clk;

  logic [15:0] rdata_a, rdata_b, wdata_a, wdata_b, mem_rdata = 16'hFFFF;
  logic [AW-1:0] maddr_a, maddr_b, ef_a, el_a, ef_b, el_b;
  logic we_a, we_b, ers_a, ers_b;
  logic [AW-1:0] cap_fa = '0, cap_la = '0, cap_fb = '0, cap_lb = '0;

  flash_cmd_ctrl #(.AW(AW), .PGM_CYCLES(PGM_CYCLES), .ERS_CYCLES(40), .TOP_BOOT(1'b1)) dut_i (
    .clk, .rst_n, .vpp_ok, .bus_we, .bus_re, .bus_addr, .bus_wdata, .bus_rdata(rdata_a),
    .mem_addr(maddr_a), .mem_rdata(mem_rdata), .mem_we(we_a), .mem_wdata(wdata_a),
    .mem_ers(ers_a), .mem_ers_first(ef_a), .mem_ers_last(el_a));

  flash_cmd_ctrl #(.AW(AW), .PGM_CYCLES(PGM_CYCLES), .ERS_CYCLES(40), .TOP_BOOT(1'b0)) dut_b (
    .clk, .rst_n, .vpp_ok, .bus_we, .bus_re, .bus_addr, .bus_wdata, .bus_rdata(rdata_b),
    .mem_addr(maddr_b), .mem_rdata(16'hFFFF), .mem_we(we_b), .mem_wdata(wdata_b),
    .mem_ers(ers_b), .mem_ers_first(ef_b), .mem_ers_last(el_b));

  logic [15:0] mem_m [int unsigned];
  always @(posedge clk) begin
    mem_rdata <= mem_m.exists(int'(maddr_a)) ? mem_m[int'(maddr_a)] : 16'hFFFF;
    if (we_a) mem_m[int'(maddr_a)] = wdata_a;
    if (ers_a) for (int unsigned k = int'(ef_a); k <= int'(el_a); k++)
      if (mem_m.exists(k)) mem_m.delete(k);
    if (ers_a) begin cap_fa <= ef_a; cap_la <= el_a; end
    if (ers_b) begin cap_fb <= ef_b; cap_lb <= el_b; end
  end

  int n_chk = 0, n_err = 0;
  bit fin = 1'b0;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [15:0] d);
    @(negedge clk); bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_we = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [15:0] d, output logic [15:0] db);
    @(negedge clk); bus_re = 1'b1; bus_addr = a;
    @(negedge clk); bus_re = 1'b0; d = rdata_a; db = rdata_b;
  endtask

  task automatic rchk(input string tag, input logic [AW-1:0] a, input logic [15:0] e);
    logic [15:0] d, db;
    rd(a, d, db);
    check(tag, {16'h0, d}, {16'h0, e});
  endtask

  task automatic wait_ready(input string tag);
    logic [15:0] d, db;
    bit ok = 1'b0;
    for (int i = 0; i < 500; i++) begin
      rd('0, d, db);
      if (d[7]) begin ok = 1'b1; break; end
    end
    if (!ok) check({tag, " ready timeout"}, 32'h0, 32'h1);
  endtask

  function automatic logic [57:0] vw(input logic [3:0] rq, input logic [19:0] a, input logic [15:0] d);
    return {2'd0, rq, a, d, 16'h0};
  endfunction
  function automatic logic [57:0] vr(input logic [3:0] rq, input logic [19:0] a, input logic [15:0] e);
    return {2'd1, rq, a, 16'h0, e};
  endfunction
  function automatic logic [57:0] vq(input logic [3:0] rq);
    return {2'd2, rq, 20'h0, 16'h0, 16'h0};
  endfunction

  localparam int NV = 55;
  localparam logic [57:0] VEC [NV] = '{
    vr(1, 20'h00100, 16'hFFFF),                                      // R1 reset mode
    vw(3, 0, 16'h0070), vr(3, 0, 16'h0080),                          // R3 status
    vw(2, 0, 16'h0090), vr(2, 0, 16'h002C), vr(2, 1, 16'h4492),      // R2 identify
    vr(2, 2, 16'h0000),
    vw(1, 0, 16'h00FF), vr(1, 20'h00100, 16'hFFFF),                  // R1 back to array
    vw(4, 0, 16'h0040), vw(4, 20'h00100, 16'hA5F0), vq(4),           // R4 program
    vr(4, 0, 16'h0080), vw(4, 0, 16'h00FF), vr(4, 20'h00100, 16'hA5F0),
    vw(4, 0, 16'h0010), vw(4, 20'h00100, 16'h0FFF), vq(4),           // R4 ones keep zeros
    vw(4, 0, 16'h00FF), vr(4, 20'h00100, 16'h05F0),
    vw(5, 0, 16'h0040), vw(5, 20'hF8005, 16'h0000), vq(5),
    vw(5, 0, 16'h0040), vw(5, 20'hF9000, 16'h0000), vq(5),
    vw(5, 0, 16'h0040), vw(5, 20'h07FFF, 16'h00FF), vq(5),
    vw(5, 0, 16'h0020), vw(5, 20'hF8123, 16'h00D0), vq(5),           // R5 erase parameter block
    vr(5, 0, 16'h0080),
    vw(5, 0, 16'h00FF), vr(5, 20'hF8005, 16'hFFFF), vr(5, 20'hF9000, 16'h0000),
    vr(5, 20'h07FFF, 16'h00FF),
    vw(5, 0, 16'h0020), vw(5, 20'h04000, 16'h00D0), vq(5),           // R5 erase main block
    vw(5, 0, 16'h00FF), vr(5, 20'h00100, 16'hFFFF), vr(5, 20'h07FFF, 16'hFFFF),
    vr(5, 20'hF9000, 16'h0000),
    vw(6, 0, 16'h0020), vw(6, 20'hF9000, 16'h00FF), vr(6, 0, 16'h00B0), // R6 bad confirm
    vw(6, 0, 16'h00FF), vr(6, 20'hF9000, 16'h0000),
    vw(10, 0, 16'h0070), vr(10, 0, 16'h00B0), vw(10, 0, 16'h0050),  // R10 sticky then clear
    vr(10, 20'hF9000, 16'h0000), vw(10, 0, 16'h0070), vr(10, 0, 16'h0080)
  };

  initial begin
    logic [15:0] d, db;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      logic [57:0] v;
      v = VEC[i];
      case (v[57:56])
        2'd0: wr(v[51:32], v[31:16]);
        2'd1: rchk($sformatf("R%0d vector %0d", v[55:52], i), v[51:32], v[15:0]);
        default: wait_ready($sformatf("R%0d vector %0d", v[55:52], i));
      endcase
    end

    // R5 block decode, both placements
    check("R5 top main first", cap_fa, 20'h00000);
    check("R5 top main last", cap_la, 20'h07FFF);
    check("R5 bottom param first", cap_fb, 20'h04000);
    check("R5 bottom param last", cap_lb, 20'h04FFF);

    // R2 identifier for both placements
    wr(0, 16'h0090);
    rd(1, d, db);
    check("R2 top device id", d, 16'h4492);
    check("R2 bottom device id", db, 16'h4493);
    wr(0, 16'h00FF);

    // R3 status latched at the strobe
    wr(0, 16'h0040); wr(20'h00800, 16'h1234);
    rchk("R3 busy status", 0, 16'h0000);
    repeat (PGM_CYCLES + 4) @(negedge clk);
    check("R3 held without strobe", rdata_a, 16'h0000);
    rchk("R3 refreshed by strobe", 0, 16'h0080);

    // R7 commands ignored while programming
    wr(0, 16'h0040); wr(20'h00900, 16'h0001);
    wr(0, 16'h00FF); wr(0, 16'h0090);
    wait_ready("R7");
    rchk("R7 mode kept status", 0, 16'h0080);
    wr(0, 16'h00FF);
    rchk("R7 program completed", 20'h00900, 16'h0001);

    // R8 / R12 program suspend
    wr(0, 16'h0040); wr(20'h00300, 16'h00AA); wr(0, 16'h00B0);
    rchk("R8 suspended status", 0, 16'h0084);
    wr(0, 16'h00FF);
    rchk("R8 not yet programmed", 20'h00300, 16'hFFFF);
    wr(0, 16'h0090);
    rchk("R12 identify ignored", 0, 16'hFFFF);
    wr(0, 16'h0040); wr(20'h00300, 16'h0000);
    rchk("R12 program setup ignored", 20'h00300, 16'hFFFF);
    repeat (20) @(negedge clk);
    wr(0, 16'h0070);
    rchk("R8 no progress while suspended", 0, 16'h0084);
    wr(0, 16'h00D0);
    rchk("R8 resumed busy", 0, 16'h0000);
    wait_ready("R8");
    wr(0, 16'h00FF);
    rchk("R8 program finished", 20'h00300, 16'h00AA);

    // R9 erase suspend with nested program
    wr(0, 16'h0040); wr(20'hFA010, 16'h1111); wait_ready("R9 prep");
    wr(0, 16'h0020); wr(20'hFA000, 16'h00D0); wr(0, 16'h00B0);
    rchk("R9 erase suspended", 0, 16'h00C0);
    wr(0, 16'h00FF);
    rchk("R9 block intact", 20'hFA010, 16'h1111);
    wr(0, 16'h0090);
    rchk("R9 identify ignored", 0, 16'hFFFF);
    wr(0, 16'h0040); wr(20'h00500, 16'h0F0F);
    rchk("R9 nested busy", 0, 16'h0040);
    wait_ready("R9 nested");
    rchk("R9 back in erase suspend", 0, 16'h00C0);
    wr(0, 16'h00FF);
    rchk("R9 nested data", 20'h00500, 16'h0F0F);
    wr(0, 16'h00D0);
    wait_ready("R9 resume");
    rchk("R8 erase resumed and done", 0, 16'h0080);
    wr(0, 16'h00FF);
    rchk("R5 resumed erase result", 20'hFA010, 16'hFFFF);
    check("R5 top param first", cap_fa, 20'hFA000);
    check("R5 top param last", cap_la, 20'hFAFFF);
    check("R5 bottom main first", cap_fb, 20'hF8000);
    check("R5 bottom main last", cap_lb, 20'hFFFFF);

    // R11 supply low
    vpp_ok = 1'b0;
    wr(0, 16'h0040); wr(20'h00600, 16'h0000);
    rchk("R11 program abort status", 0, 16'h0088);
    wr(0, 16'h00FF);
    rchk("R11 word unchanged", 20'h00600, 16'hFFFF);
    wr(0, 16'h0020); wr(0, 16'h00D0);
    rchk("R11 erase abort status", 0, 16'h0088);
    wr(0, 16'h00FF);
    rchk("R11 block not erased", 20'h00500, 16'h0F0F);
    vpp_ok = 1'b1;
    wr(0, 16'h0050);

    // R1 reset clears flags and mode
    wr(0, 16'h0020); wr(0, 16'h00FF);
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk); rst_n = 1'b1;
    rchk("R1 array after reset", 20'h00500, 16'h0F0F);
    wr(0, 16'h0070);
    rchk("R1 status after reset", 0, 16'h0080);

    fin = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!fin) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule